// File: doc/BRIEF.md
# Clock Frequency Monitor with Guarded Configuration

This block checks that a monitored clock runs at the expected rate. It measures against a trusted reference clock. Each measurement window lasts a fixed number of reference cycles. During the window the block counts rising edges of the monitored clock. It then checks the count against a programmable lower and upper limit. A count outside the limits sets a sticky frequency-error flag. If software has allowed it, the block also issues a fixed-length reset request and records a sticky reset-cause flag. Only a power-on reset or an explicit write clears that cause flag.

Software reaches the block through a simple synchronous register port in the reference-clock domain. All configuration is guarded by magic values. A key register opens and closes configuration access, and monitoring starts and stops only on dedicated codes. The normal flow has four steps:

1. Disable monitoring.
2. Program the limits.
3. Enable monitoring.
4. Wait until the busy flag drops before trusting the error flag.

Top module: `freqmon`

## Requirements
- R1: The key register (address 0) opens configuration on a write of 0x00F9 and closes it on a write of 0x0006. Other values change nothing. Reading address 0 returns 1 in bit 0 while configuration is closed.
- R2: While configuration is closed, writes are ignored at these addresses:
  - control (address 1)
  - minimum limit (address 2)
  - maximum limit (address 3)
  - reset-enable (address 4)
- R3: A write of 0x00E4 to control starts monitoring and a write of 0x0000 stops it. Any other value leaves the state unchanged. Control reads back 0x00E4 while monitoring and 0x0000 otherwise.
- R4: The status busy bit (address 5, bit 0) reads 1 from the enabling write until the first window has been evaluated, then 0. It is 0 whenever monitoring is off.
- R5: A window count below the minimum limit sets the error bit (address 5, bit 1). A count equal to the minimum is in range.
- R6: A window count above the maximum limit sets the error bit. A count equal to the maximum is in range.
- R7: Writes to either limit register are ignored while monitoring runs.
- R8: With reset-enable bit 0 (address 4) at 0, an error sets only the flag and `resetReq` stays low. With it at 1, an error raises `resetReq` for exactly RST_PULSE reference cycles.
- R9: The error bit is sticky. Writing 1 to status bit 1 clears it.
- R10: The cause flag (address 6, bit 0) is set when a reset request is issued. It survives `rstN` and is cleared only by writing 1 to bit 0 or by `porN`.
- R11: After reset the block is in this state:
  - configuration closed
  - monitoring off
  - both limits 0
  - reset output disabled
  - status 0
  - cause flag 0 after power-on

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| refClk | input | 1 | Trusted reference clock; all registers live here |
| rstN | input | 1 | Active-low asynchronous system reset |
| porN | input | 1 | Active-low power-on reset, also clears the cause flag |
| monClk | input | 1 | Clock under observation |
| busWe | input | 1 | Register write strobe |
| busAddr | input | 3 | Register address |
| busWdata | input | DW | Write data |
| busRdata | output | DW | Read data for busAddr, combinational |
| resetReq | output | 1 | Reset request pulse on a detected frequency error |

## Verification
The bench builds the block with a 32-cycle window and a 4-cycle reset pulse, so that every measurement finishes within a few dozen cycles. The monitored clock is derived from the reference with a fixed phase. This makes window counts exact (16, 32 or 64, or 0 when stopped). With exact counts, the boundary cases where the count equals a limit, and where it misses a limit by one, can be checked without any tolerance.

// File: rtl/freqmon_pkg.sv
package freqmon_pkg;

  localparam logic [2:0] ADDR_KEY   = 3'd0;
  localparam logic [2:0] ADDR_CTRL  = 3'd1;
  localparam logic [2:0] ADDR_MIN   = 3'd2;
  localparam logic [2:0] ADDR_MAX   = 3'd3;
  localparam logic [2:0] ADDR_RSTEN = 3'd4;
  localparam logic [2:0] ADDR_STAT  = 3'd5;
  localparam logic [2:0] ADDR_CAUSE = 3'd6;

  localparam logic [7:0] KEY_OPEN = 8'hF9;
  localparam logic [7:0] KEY_SHUT = 8'h06;
  localparam logic [7:0] RUN_ON   = 8'hE4;
  localparam logic [7:0] RUN_OFF  = 8'h00;

  // control -> datapath strobes
  typedef struct packed {
    logic start;  // restart window and take a new baseline
    logic run;    // monitoring enabled
  } meas_ctrl_t;

  // datapath -> control result
  typedef struct packed {
    logic done;   // one-cycle pulse after a window closes
    logic low;    // count under the minimum
    logic high;   // count over the maximum
  } meas_res_t;

endpackage

// File: rtl/freqmon_datapath.sv
module freqmon_datapath
  import freqmon_pkg::*;
#(
  parameter int LIM_W  = 9,
  parameter int WINDOW = 256,
  parameter int CW     = LIM_W + 3
) (
  input  logic             refClk,
  input  logic             rstN,
  input  logic             monClk,
  input  meas_ctrl_t       measCtrl,
  input  logic [LIM_W-1:0] minLim,
  input  logic [LIM_W-1:0] maxLim,
  output meas_res_t        measRes
);
  localparam int WW = (WINDOW > 1) ? $clog2(WINDOW) : 1;
  localparam logic [WW-1:0] LAST = WW'(WINDOW - 1);

  // monitored-clock domain: binary counter with registered gray copy
  logic [CW-1:0] monBin, monBinNxt, monGray;
  assign monBinNxt = monBin + 1'b1;

  always_ff @(posedge monClk or negedge rstN) begin
    if (!rstN) begin
      monBin  <= '0;
      monGray <= '0;
    end else begin
      monBin  <= monBinNxt;
      monGray <= monBinNxt ^ (monBinNxt >> 1);
    end
  end

  // two-stage synchroniser into the reference domain
  logic [CW-1:0] syncA, syncB;
  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= monGray;
      syncB <= syncA;
    end
  end

  logic [CW-1:0] curBin;
  always_comb begin
    curBin[CW-1] = syncB[CW-1];
    for (int i = CW - 2; i >= 0; i--) curBin[i] = curBin[i+1] ^ syncB[i];
  end

  logic [CW-1:0] baseBin, edgeCount, minExt, maxExt;
  logic [WW-1:0] winCnt;

  assign edgeCount = curBin - baseBin;
  assign minExt    = {{(CW-LIM_W){1'b0}}, minLim};
  assign maxExt    = {{(CW-LIM_W){1'b0}}, maxLim};

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      winCnt  <= '0;
      baseBin <= '0;
      measRes <= '0;
    end else begin
      measRes.done <= 1'b0;
      if (measCtrl.start) begin
        winCnt  <= '0;
        baseBin <= curBin;
        measRes <= '0;
      end else if (measCtrl.run) begin
        if (winCnt == LAST) begin
          winCnt       <= '0;
          baseBin      <= curBin;
          measRes.done <= 1'b1;
          measRes.low  <= edgeCount < minExt;
          measRes.high <= edgeCount > maxExt;
        end else begin
          winCnt <= winCnt + 1'b1;
        end
      end else begin
        winCnt <= '0;
      end
    end
  end

endmodule

// File: rtl/freqmon_ctrl.sv
module freqmon_ctrl
  import freqmon_pkg::*;
#(
  parameter int DW        = 16,
  parameter int LIM_W     = 9,
  parameter int RST_PULSE = 4
) (
  input  logic             refClk,
  input  logic             rstN,
  input  logic             porN,
  input  logic             busWe,
  input  logic [2:0]       busAddr,
  input  logic [DW-1:0]    busWdata,
  input  meas_res_t        measRes,
  output logic [DW-1:0]    busRdata,
  output logic             resetReq,
  output meas_ctrl_t       measCtrl,
  output logic [LIM_W-1:0] minLim,
  output logic [LIM_W-1:0] maxLim,
  output logic             locked,
  output logic             enabled,
  output logic             busy,
  output logic             rstOutEn,
  output logic             freqErr,
  output logic             causeFlag
);
  localparam int PW = $clog2(RST_PULSE + 1);
  localparam logic [DW-1:0] W_OPEN = DW'(KEY_OPEN);
  localparam logic [DW-1:0] W_SHUT = DW'(KEY_SHUT);
  localparam logic [DW-1:0] W_ON   = DW'(RUN_ON);
  localparam logic [DW-1:0] W_OFF  = DW'(RUN_OFF);

  logic [PW-1:0] pulseLeft;
  logic          startQ;
  logic          cfgWr, detect, fireRst;

  assign cfgWr   = busWe && !locked;
  assign detect  = enabled && measRes.done && (measRes.low || measRes.high);
  assign fireRst = detect && rstOutEn && (pulseLeft == '0);

  assign resetReq       = (pulseLeft != '0);
  assign measCtrl.start = startQ;
  assign measCtrl.run   = enabled;

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      locked    <= 1'b1;
      enabled   <= 1'b0;
      startQ    <= 1'b0;
      busy      <= 1'b0;
      minLim    <= '0;
      maxLim    <= '0;
      rstOutEn  <= 1'b0;
      freqErr   <= 1'b0;
      pulseLeft <= '0;
    end else begin
      startQ <= 1'b0;

      if (busWe && busAddr == ADDR_KEY) begin
        if (busWdata == W_OPEN)      locked <= 1'b0;
        else if (busWdata == W_SHUT) locked <= 1'b1;
      end

      if (enabled && measRes.done) busy <= 1'b0;

      if (cfgWr && busAddr == ADDR_CTRL) begin
        if (busWdata == W_ON && !enabled) begin
          enabled <= 1'b1;
          startQ  <= 1'b1;
          busy    <= 1'b1;
        end else if (busWdata == W_OFF) begin
          enabled <= 1'b0;
          busy    <= 1'b0;
        end
      end

      if (cfgWr && !enabled && busAddr == ADDR_MIN) minLim <= busWdata[LIM_W-1:0];
      if (cfgWr && !enabled && busAddr == ADDR_MAX) maxLim <= busWdata[LIM_W-1:0];
      if (cfgWr && busAddr == ADDR_RSTEN)           rstOutEn <= busWdata[0];

      if (detect) freqErr <= 1'b1;
      else if (busWe && busAddr == ADDR_STAT && busWdata[1]) freqErr <= 1'b0;

      if (fireRst)                pulseLeft <= PW'(RST_PULSE);
      else if (pulseLeft != '0)   pulseLeft <= pulseLeft - 1'b1;
    end
  end

  // cause flag lives on the power-on reset only
  always_ff @(posedge refClk or negedge porN) begin
    if (!porN)                                              causeFlag <= 1'b0;
    else if (fireRst)                                       causeFlag <= 1'b1;
    else if (busWe && busAddr == ADDR_CAUSE && busWdata[0]) causeFlag <= 1'b0;
  end

  always_comb begin
    busRdata = '0;
    case (busAddr)
      ADDR_KEY:   busRdata = {{(DW-1){1'b0}}, locked};
      ADDR_CTRL:  busRdata = enabled ? W_ON : W_OFF;
      ADDR_MIN:   busRdata = {{(DW-LIM_W){1'b0}}, minLim};
      ADDR_MAX:   busRdata = {{(DW-LIM_W){1'b0}}, maxLim};
      ADDR_RSTEN: busRdata = {{(DW-1){1'b0}}, rstOutEn};
      ADDR_STAT:  busRdata = {{(DW-2){1'b0}}, freqErr, busy};
      ADDR_CAUSE: busRdata = {{(DW-1){1'b0}}, causeFlag};
      default:    busRdata = '0;
    endcase
  end

endmodule

// File: rtl/freqmon.sv
module freqmon
  import freqmon_pkg::*;
#(
  parameter int DW        = 16,
  parameter int LIM_W     = 9,
  parameter int WINDOW    = 256,
  parameter int RST_PULSE = 4,
  parameter int CW        = LIM_W + 3
) (
  input  logic          refClk,
  input  logic          rstN,
  input  logic          porN,
  input  logic          monClk,
  input  logic          busWe,
  input  logic [2:0]    busAddr,
  input  logic [DW-1:0] busWdata,
  output logic [DW-1:0] busRdata,
  output logic          resetReq
);
  meas_ctrl_t       measCtrl;
  meas_res_t        measRes;
  logic [LIM_W-1:0] minLim, maxLim;
  logic             locked, enabled, busy, rstOutEn, freqErr, causeFlag;

  freqmon_ctrl #(.DW(DW), .LIM_W(LIM_W), .RST_PULSE(RST_PULSE)) u_ctrl (
    .refClk(refClk), .rstN(rstN), .porN(porN),
    .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata),
    .measRes(measRes), .busRdata(busRdata), .resetReq(resetReq),
    .measCtrl(measCtrl), .minLim(minLim), .maxLim(maxLim),
    .locked(locked), .enabled(enabled), .busy(busy),
    .rstOutEn(rstOutEn), .freqErr(freqErr), .causeFlag(causeFlag)
  );

  freqmon_datapath #(.LIM_W(LIM_W), .WINDOW(WINDOW), .CW(CW)) u_dp (
    .refClk(refClk), .rstN(rstN), .monClk(monClk),
    .measCtrl(measCtrl), .minLim(minLim), .maxLim(maxLim),
    .measRes(measRes)
  );

endmodule

// File: rtl/freqmon_chk.sv
module freqmon_chk
  import freqmon_pkg::*;
#(
  parameter int LIM_W     = 9,
  parameter int RST_PULSE = 4
) (
  input logic             refClk,
  input logic             rstN,
  input logic             busWe,
  input logic [2:0]       busAddr,
  input logic             resetReq,
  input logic             locked,
  input logic             enabled,
  input logic             busy,
  input logic             rstOutEn,
  input logic             causeFlag,
  input logic [LIM_W-1:0] minLim,
  input logic [LIM_W-1:0] maxLim
);
  logic [7:0] highRun;

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN)         highRun <= '0;
    else if (resetReq) highRun <= highRun + 1'b1;
    else               highRun <= '0;
  end

  p_pulse_max_r8: assert property (@(posedge refClk) disable iff (!rstN)
    resetReq |-> (highRun < 8'(RST_PULSE)));

  p_pulse_len_r8: assert property (@(posedge refClk) disable iff (!rstN)
    $fell(resetReq) |-> (highRun == 8'(RST_PULSE)));

  p_req_needs_en_r8: assert property (@(posedge refClk) disable iff (!rstN)
    $rose(resetReq) |-> $past(rstOutEn));

  p_cause_set_r10: assert property (@(posedge refClk) disable iff (!rstN)
    $rose(resetReq) |-> causeFlag);

  p_locked_min_r2: assert property (@(posedge refClk) disable iff (!rstN)
    (locked && busWe && busAddr == ADDR_MIN) |=> $stable(minLim));

  p_frozen_lim_r7: assert property (@(posedge refClk) disable iff (!rstN)
    enabled |=> ($stable(minLim) && $stable(maxLim)));

  p_busy_enabled_r4: assert property (@(posedge refClk) disable iff (!rstN)
    busy |-> enabled);

endmodule

bind freqmon freqmon_chk #(.LIM_W(LIM_W), .RST_PULSE(RST_PULSE)) u_chk (
  .refClk(refClk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
  .resetReq(resetReq), .locked(locked), .enabled(enabled), .busy(busy),
  .rstOutEn(rstOutEn), .causeFlag(causeFlag), .minLim(minLim), .maxLim(maxLim)
);

// File: tb/freqmon_tb.sv
`timescale 1ns/1ps
module freqmon_tb;
  localparam int CLK = 20;
  localparam int DW  = 16;
  localparam int WIN = 32;

  logic refClk = 0, rstN = 0, porN = 0, monClk = 0, busWe = 0;
  logic [2:0]    busAddr = '0;
  logic [DW-1:0] busWdata = '0;
  logic [DW-1:0] busRdata;
  logic          resetReq;
  int monMode = 0;
  int errors = 0, checks = 0;
  int runLen = 0, lastPulseLen = 0, totalHigh = 0;
  bit finished = 0;

  typedef struct {
    logic [2:0]    addr;
    logic [DW-1:0] exp;
    string         tag;
  } item_t;
  item_t sbq[$];

  freqmon #(.DW(DW), .WINDOW(WIN), .RST_PULSE(4)) u_dut (
    .refClk(refClk), .rstN(rstN), .porN(porN), .monClk(monClk),
    .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .resetReq(resetReq)
  );

  always #(CLK/2) refClk = ~refClk;

  // monitored clock, phase-locked to the reference: 1 = same rate, 2 = half, 3 = double, else stopped
  always @(posedge refClk) begin
    case (monMode)
      1: begin #5 monClk = 1; #10 monClk = 0; end
      2: begin #5 monClk = ~monClk; end
      3: begin #3 monClk = 1; #5 monClk = 0; #5 monClk = 1; #5 monClk = 0; end
      default: ;
    endcase
  end

  task automatic score(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: compares queued reads against busRdata
  always @(posedge refClk) begin
    #2;
    if (sbq.size() > 0) begin
      item_t it;
      it = sbq.pop_front();
      score(it.tag, busRdata, it.exp);
    end
    if (resetReq) begin
      runLen++;
      totalHigh++;
    end else if (runLen != 0) begin
      lastPulseLen = runLen;
      runLen = 0;
    end
  end

  task automatic wr(logic [2:0] a, logic [DW-1:0] d);
    @(negedge refClk);
    busWe = 1; busAddr = a; busWdata = d;
    @(negedge refClk);
    busWe = 0;
  endtask

  task automatic expect_rd(logic [2:0] a, logic [DW-1:0] e, string tag);
    item_t it;
    @(negedge refClk);
    busAddr = a;
    it.addr = a; it.exp = e; it.tag = tag;
    sbq.push_back(it);
    @(posedge refClk);
    #3;
  endtask

  task automatic waitc(int n);
    repeat (n) @(posedge refClk);
  endtask

  task automatic measure(int mode, int mn, int mx);
    wr(3'd1, 16'h0000);
    monMode = mode;
    wr(3'd5, 16'h0002);
    wr(3'd2, DW'(mn));
    wr(3'd3, DW'(mx));
    wr(3'd1, 16'h00E4);
    waitc(WIN + 8);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge refClk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    waitc(3);
    @(negedge refClk);
    rstN = 1; porN = 1;
    waitc(2);

    // R11 reset values
    expect_rd(3'd0, 16'h0001, "R11 key locked after reset");
    expect_rd(3'd1, 16'h0000, "R11 control off after reset");
    expect_rd(3'd2, 16'h0000, "R11 min zero");
    expect_rd(3'd3, 16'h0000, "R11 max zero");
    expect_rd(3'd4, 16'h0000, "R11 reset output disabled");
    expect_rd(3'd5, 16'h0000, "R11 status clear");
    expect_rd(3'd6, 16'h0000, "R11 cause clear after power-on");

    // R2 locked writes ignored
    wr(3'd2, 16'd20);
    wr(3'd3, 16'd40);
    wr(3'd4, 16'h0001);
    wr(3'd1, 16'h00E4);
    expect_rd(3'd2, 16'h0000, "R2 min ignored while locked");
    expect_rd(3'd3, 16'h0000, "R2 max ignored while locked");
    expect_rd(3'd4, 16'h0000, "R2 reset-enable ignored while locked");
    expect_rd(3'd1, 16'h0000, "R2 control ignored while locked");

    // R1 unlock, bad key no effect
    wr(3'd0, 16'h0055);
    expect_rd(3'd0, 16'h0001, "R1 wrong key keeps lock");
    wr(3'd0, 16'h00F9);
    expect_rd(3'd0, 16'h0000, "R1 unlock key");

    // R3 other value no effect
    wr(3'd1, 16'h0055);
    expect_rd(3'd1, 16'h0000, "R3 other value leaves off");

    // R4, R5, R6 equality with exact count 32
    monMode = 1;
    wr(3'd2, 16'd32);
    wr(3'd3, 16'd32);
    expect_rd(3'd2, 16'd32, "R7 min writable while off");
    wr(3'd1, 16'h00E4);
    expect_rd(3'd1, 16'h00E4, "R3 enable reads back");
    expect_rd(3'd5, 16'h0001, "R4 busy after enable");
    wr(3'd1, 16'h0055);
    expect_rd(3'd1, 16'h00E4, "R3 other value leaves on");
    wr(3'd2, 16'd5);
    wr(3'd3, 16'd99);
    expect_rd(3'd2, 16'd32, "R7 min frozen while on");
    expect_rd(3'd3, 16'd32, "R7 max frozen while on");
    waitc(WIN + 8);
    expect_rd(3'd5, 16'h0000, "R5 R6 count equal to both limits in range, R4 busy cleared");
    wr(3'd1, 16'h0000);
    expect_rd(3'd1, 16'h0000, "R3 disable");

    // R5 below min by one
    measure(1, 33, 100);
    expect_rd(3'd5, 16'h0002, "R5 count under min");
    score("R8 no reset request when disabled output", DW'(totalHigh), 16'd0);

    // R9 sticky and cleared by W1C
    wr(3'd1, 16'h0000);
    waitc(2);
    expect_rd(3'd5, 16'h0002, "R9 error sticky after stop");
    wr(3'd5, 16'h0001);
    expect_rd(3'd5, 16'h0002, "R9 write 0 to bit1 keeps error");
    wr(3'd5, 16'h0002);
    expect_rd(3'd5, 16'h0000, "R9 write 1 clears error");

    // R6 above max by one
    measure(1, 0, 31);
    expect_rd(3'd5, 16'h0002, "R6 count over max");

    // other rates
    measure(2, 16, 16);
    expect_rd(3'd5, 16'h0000, "R5 half rate count 16 in range");
    measure(3, 64, 64);
    expect_rd(3'd5, 16'h0000, "R6 double rate count 64 in range");
    measure(3, 0, 63);
    expect_rd(3'd5, 16'h0002, "R6 double rate over 63");

    // R8 reset pulse with output enabled, stopped clock
    wr(3'd1, 16'h0000);
    wr(3'd4, 16'h0001);
    expect_rd(3'd4, 16'h0001, "R8 reset-enable set");
    score("R8 no request before enabling output", DW'(totalHigh), 16'd0);
    measure(0, 10, 100);
    waitc(4);
    wr(3'd1, 16'h0000);
    waitc(8);
    score("R8 pulse length", DW'(lastPulseLen), 16'd4);
    expect_rd(3'd6, 16'h0001, "R10 cause set by request");

    // R1 lock again, R10 survives system reset
    wr(3'd0, 16'h0006);
    expect_rd(3'd0, 16'h0001, "R1 lock key");
    @(negedge refClk); rstN = 0;
    waitc(2);
    @(negedge refClk); rstN = 1;
    waitc(2);
    expect_rd(3'd6, 16'h0001, "R10 cause survives system reset");
    expect_rd(3'd4, 16'h0000, "R11 reset-enable cleared by system reset");
    wr(3'd6, 16'h0001);
    expect_rd(3'd6, 16'h0000, "R10 cause cleared by write");

    // R10 set again, then cleared by power-on reset
    wr(3'd0, 16'h00F9);
    wr(3'd4, 16'h0001);
    measure(0, 10, 100);
    wr(3'd1, 16'h0000);
    waitc(8);
    expect_rd(3'd6, 16'h0001, "R10 cause set again");
    @(negedge refClk); rstN = 0; porN = 0;
    waitc(2);
    @(negedge refClk); rstN = 1; porN = 1;
    waitc(2);
    expect_rd(3'd6, 16'h0000, "R10 cause cleared by power-on");

    waitc(3);
    finished = 1;
    finish_run();
  end

endmodule